// File: doc/BRIEF.md
# Two-Input Stream Join

The join takes two independent streams, A and B, each carried by a data word, a valid flag and a ready flag. It emits one output stream through a single holding register. A pair is taken only on a cycle where both inputs offer a word and the output stage has room. The stage has room when its register is empty or is being drained that same cycle. The captured output word places the A word in the upper half and the B word in the lower half. It stays in the register until the downstream side takes it.

Neither input is ever consumed alone. Each input's ready depends on the other input's valid and on the output stage, and never on its own valid. This lets a producer that waits for ready before raising valid connect without a combinational loop.

Reset is asserted asynchronously from an active-low pin. Its release is synchronised inside the block over two clock edges. Both readies stay low until that release has completed.

Top module: `pair_stream_join`

## Requirements
- R1: While reset is held, `y_vld` and `y_dat` are 0. Asserting `rst_n` low clears them at once, without waiting for a clock edge.
- R2: `a_rdy` equals `b_vld && (y_rdy || !y_vld)` once reset release has completed. It does not depend on `a_vld`.
- R3: `b_rdy` equals `a_vld && (y_rdy || !y_vld)` once reset release has completed. It does not depend on `b_vld`.
- R4: On a clock edge where `a_vld`, `b_vld` and `(y_rdy || !y_vld)` are all high, the register captures the pair. From the next cycle `y_vld` is 1, `y_dat[31:16]` holds `a_dat` and `y_dat[15:0]` holds `b_dat`.
- R5: On an edge where only one of `a_vld` and `b_vld` is high, no pair is taken. Both the input being offered and the output register are left unchanged.
- R6: While `y_vld` is 1 and `y_rdy` is 0, `y_vld` stays 1 and `y_dat` keeps its value across the edge, whatever the inputs do.
- R7: After an edge where `y_vld` and `y_rdy` are both 1 and no pair is taken, `y_vld` is 0. `y_dat` keeps the last word.
- R8: With `y_rdy` held at 1 and both inputs valid, a new pair is taken on every edge, with no bubble cycles.
- R9: After `rst_n` rises, `a_rdy` and `b_rdy` stay 0 through the first clock edge. They may rise only after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_vld | input | 1 | Input A offers a word |
| a_dat | input | 16 | Input A word |
| a_rdy | output | 1 | Input A word is taken this edge if offered |
| b_vld | input | 1 | Input B offers a word |
| b_dat | input | 16 | Input B word |
| b_rdy | output | 1 | Input B word is taken this edge if offered |
| y_vld | output | 1 | Output register holds a pair |
| y_dat | output | 32 | Joined pair, A upper, B lower |
| y_rdy | input | 1 | Downstream takes the output word this edge |

## Verification
The two input readies are combinational. They are due in the same cycle as the valids and `y_vld` that drive them, so the bench samples them one nanosecond after driving the inputs on the falling edge. The output valid and word change one rising edge after a take or a drain, and the bench samples them one nanosecond after that edge. Reset assertion is checked a moment after `rst_n` falls, with no edge in between. Reset release is checked after the first and after the second rising edge.

// File: rtl/pj_pkg.sv
package pj_pkg;
  // Output stage has room: empty, or being drained on this edge.
  function automatic logic stage_room(input logic held, input logic taken);
    return taken || !held;
  endfunction
endpackage

// File: rtl/pj_rst_sync.sv
module pj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/pj_join_ctrl.sv
module pj_join_ctrl (
  input  logic clk,
  input  logic rst_q_n,
  input  logic a_vld,
  input  logic b_vld,
  input  logic y_vld,
  input  logic y_rdy,
  output logic a_rdy,
  output logic b_rdy,
  output logic take
);
  import pj_pkg::*;
  logic room;

  always_comb begin
    room  = rst_q_n && stage_room(y_vld, y_rdy);
    a_rdy = room && b_vld;
    b_rdy = room && a_vld;
    take  = room && a_vld && b_vld;
  end

  // R5: both sides are consumed together or not at all
  p_pair_only_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (a_vld && a_rdy) == (b_vld && b_rdy));
  // R2: A is never offered a ready without B present
  p_a_needs_b_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    a_rdy |-> b_vld);
  // R3
  p_b_needs_a_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    b_rdy |-> a_vld);
endmodule

// File: rtl/pj_hold_reg.sv
module pj_hold_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         dn_rdy,
  output logic         vld_q,
  output logic [W-1:0] dat_q
);
  logic         vld_d;
  logic [W-1:0] dat_d;

  always_comb begin
    vld_d = load || (vld_q && !dn_rdy);
    dat_d = load ? din : dat_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  // R6: a stalled word neither vanishes nor changes
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_q && !dn_rdy) |=> (vld_q && $stable(dat_q)));
  // R4: a take shows up as valid on the next cycle
  p_take_valid_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    load |=> vld_q);
  // R7: drained with nothing new means empty
  p_drain_empty_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_q && dn_rdy && !load) |=> !vld_q);
endmodule

// File: rtl/pair_stream_join.sv
module pair_stream_join #(
  parameter int HALF_W = 16,
  localparam int OUT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_vld,
  input  logic [HALF_W-1:0] a_dat,
  output logic              a_rdy,
  input  logic              b_vld,
  input  logic [HALF_W-1:0] b_dat,
  output logic              b_rdy,
  output logic              y_vld,
  output logic [OUT_W-1:0]  y_dat,
  input  logic              y_rdy
);
  logic rst_q_n;
  logic take;

  pj_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  pj_join_ctrl u_ctrl (
    .clk(clk), .rst_q_n(rst_q_n),
    .a_vld(a_vld), .b_vld(b_vld),
    .y_vld(y_vld), .y_rdy(y_rdy),
    .a_rdy(a_rdy), .b_rdy(b_rdy), .take(take)
  );

  pj_hold_reg #(.W(OUT_W)) u_hold (
    .clk(clk), .rst_q_n(rst_q_n),
    .load(take), .din({a_dat, b_dat}), .dn_rdy(y_rdy),
    .vld_q(y_vld), .dat_q(y_dat)
  );

  // R9/R1: no ready is offered while reset is in effect
  p_quiet_in_reset_r9: assert property (@(posedge clk)
    !rst_q_n |-> (!a_rdy && !b_rdy));
  // R4: captured word carries A above B
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    take |=> (y_dat == {$past(a_dat), $past(b_dat)}));
endmodule

// File: tb/sim_pair_stream_join.sv
module sim_pair_stream_join;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_vld, b_vld, y_rdy;
  logic [15:0] a_dat, b_dat;
  logic        a_rdy, b_rdy, y_vld;
  logic [31:0] y_dat;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pair_stream_join u0 (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_dat(a_dat), .a_rdy(a_rdy),
    .b_vld(b_vld), .b_dat(b_dat), .b_rdy(b_rdy),
    .y_vld(y_vld), .y_dat(y_dat), .y_rdy(y_rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {a_vld,b_vld,y_rdy, a_dat, b_dat, exp a_rdy, exp b_rdy, exp y_vld, exp y_dat}
  localparam logic [69:0] VEC [12] = '{
    {3'b100, 16'h1111, 16'h2222, 3'b010, 32'h0000_0000}, // R5 A alone
    {3'b010, 16'h3333, 16'h4444, 3'b100, 32'h0000_0000}, // R5 B alone
    {3'b110, 16'hAAAA, 16'h5555, 3'b111, 32'hAAAA_5555}, // R4 take into empty
    {3'b110, 16'h1234, 16'h5678, 3'b001, 32'hAAAA_5555}, // R6 stall
    {3'b111, 16'h1234, 16'h5678, 3'b111, 32'h1234_5678}, // R8 drain and refill
    {3'b111, 16'hDEAD, 16'hBEEF, 3'b111, 32'hDEAD_BEEF}, // R8 back to back
    {3'b001, 16'h0000, 16'h0000, 3'b000, 32'hDEAD_BEEF}, // R7 drain, data kept
    {3'b010, 16'h0000, 16'h0001, 3'b100, 32'hDEAD_BEEF}, // R2 ready from B valid
    {3'b111, 16'hFFFF, 16'h0000, 3'b111, 32'hFFFF_0000}, // R4 halves placed
    {3'b100, 16'h7777, 16'h8888, 3'b001, 32'hFFFF_0000}, // R6 stall, A alone
    {3'b010, 16'h7777, 16'h8888, 3'b001, 32'hFFFF_0000}, // R6 stall, B alone
    {3'b001, 16'h0000, 16'h0000, 3'b000, 32'hFFFF_0000}  // R7 drain
  };

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_vld = 1'b1; b_vld = 1'b1; y_rdy = 1'b0;
    a_dat = 16'hCAFE; b_dat = 16'hF00D;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 y_vld in reset", {31'd0, y_vld}, 32'd0);
    chk("R1 y_dat in reset", y_dat, 32'd0);
    chk("R9 a_rdy in reset", {31'd0, a_rdy}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 a_rdy after first edge", {31'd0, a_rdy}, 32'd0);
    chk("R9 y_vld after first edge", {31'd0, y_vld}, 32'd0);
    @(posedge clk); #1;
    chk("R9 a_rdy after second edge", {31'd0, a_rdy}, 32'd1);
    @(negedge clk); a_vld = 1'b0; b_vld = 1'b0;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {a_vld, b_vld, y_rdy} = VEC[i][69:67];
      a_dat = VEC[i][66:51];
      b_dat = VEC[i][50:35];
      #1;
      chk($sformatf("R2 a_rdy vec %0d", i), {31'd0, a_rdy}, {31'd0, VEC[i][34]});
      chk($sformatf("R3 b_rdy vec %0d", i), {31'd0, b_rdy}, {31'd0, VEC[i][33]});
      @(posedge clk); #1;
      chk($sformatf("R4/R5/R6/R7/R8 y_vld vec %0d", i), {31'd0, y_vld}, {31'd0, VEC[i][32]});
      chk($sformatf("R4/R5/R6/R7/R8 y_dat vec %0d", i), y_dat, VEC[i][31:0]);
    end

    // R1: asynchronous clear while a word is held
    @(negedge clk);
    a_vld = 1'b1; b_vld = 1'b1; y_rdy = 1'b0; a_dat = 16'h0BAD; b_dat = 16'hF00D;
    @(posedge clk); #1;
    chk("R4 load before async reset", y_dat, 32'h0BAD_F00D);
    rst_n = 1'b0;
    #0.5;
    chk("R1 y_vld async clear", {31'd0, y_vld}, 32'd0);
    chk("R1 y_dat async clear", y_dat, 32'd0);
    chk("R9 b_rdy async clear", {31'd0, b_rdy}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule